// File: doc/BRIEF.md
# Steerable watchdog timer

This block is a one-shot watchdog that counts a slow 16 Hz tick down from a programmed timeout. An 8-bit control byte sets the timeout. The low two bits are a resolution exponent and the next five bits are a multiplier. The timeout is the multiplier times four to the power of the exponent, counted in sixteenths of a second. Software keeps the watchdog alive in one of two ways: it rewrites the control byte, or it reads the flags register. The block sees that read as a strobe.

When the count runs out, the block raises a sticky expiry flag. The top bit of the control byte then picks what happens next:
- If the bit is clear, the block emits a one-cycle interrupt pulse.
- If the bit is set, the block emits a one-cycle reset request. It also clears the control byte and one bit of a separate status register.

The crystal divider that produces the tick and the host bus decoding both sit outside this block.

Top module: `wdt_steer`

## Requirements
- R1: After reset, the expiry flag, the interrupt pulse, the reset request, the control byte and the status bit are all 0, and the counter is stopped.
- R2: A control write (`wr_i`=1, `wr_sel_i`=0) does three things: it stores `wr_data_i` as the control byte, it clears the expiry flag, and it restarts the count from the new timeout.
- R3: Control bits [1:0] hold the exponent e and bits [6:2] hold the multiplier m. Expiry happens on exactly the (m·4^e)-th tick after the last reload, and never earlier.
- R4: A multiplier of 0 disables the watchdog. Ticks never cause an expiry.
- R5: A flags-register read strobe (`flag_rd_i`) clears the expiry flag and reloads the count from the stored control byte.
- R6: On expiry, the expiry flag is set. It stays set until the next control write or flags read.
- R7: With control bit 7 clear, expiry produces one 1-cycle interrupt pulse and no reset request, and it leaves the control byte unchanged.
- R8: With control bit 7 set, expiry produces one 1-cycle reset request and no interrupt pulse. It also clears the control byte to 0x00 and clears the status bit.
- R9: A status write (`wr_i`=1, `wr_sel_i`=1) stores `wr_data_i[6]` into the status bit. It neither reloads nor stops the count and does not touch the flag.
- R10: A reload (control write or flags read) in the same cycle as the final tick takes priority. No expiry, flag or pulse results, and the full timeout restarts.
- R11: The watchdog is one-shot. After an expiry, further ticks produce no further pulses until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle 16 Hz time-base strobe |
| wr_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control byte, 1 status bit |
| wr_data_i | input | 8 | Write data |
| flag_rd_i | input | 1 | Flags-register read strobe |
| wd_flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | One-cycle interrupt pulse |
| rst_req_o | output | 1 | One-cycle system reset request |
| ctrl_o | output | 8 | Current control byte |
| stat_o | output | 1 | Status bit cleared by a reset-steered expiry |

## Verification
The bench targets four kinds of error.

The first is the timeout boundary. It checks the flag one tick before the computed timeout and again on that tick, for every exponent value. A wrong shift or swapped fields would expire early or late.

The second is two strobes that collide on the final tick:
- a reload arriving together with that tick, which a design with the wrong priority would turn into a spurious interrupt;
- a status write arriving mid-count, which must not restart the count.

The third is the steering bit. A design that got it wrong would pulse the wrong output, or leave the control byte and status bit intact after a reset request.

The fourth is the disabled and one-shot cases. Long runs of ticks with a zero multiplier, or after an expiry, must produce no pulse at all. The scoreboard flags any pulse that it did not predict.

// File: rtl/wdt_steer_pkg.sv
package wdt_steer_pkg;

    localparam int REG_W     = 8;
    localparam int EXP_W     = 2;
    localparam int MULT_W    = 5;
    localparam int MULT_LSB  = EXP_W;
    localparam int STEER_POS = 7;
    localparam int STAT_POS  = 6;
    // largest timeout: multiplier max shifted by 2 * max exponent
    localparam int CNT_W     = MULT_W + 2 * ((1 << EXP_W) - 1);

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic             stat;
        logic             flag;
        logic             irq;
        logic             rst;
    } wdt_regs_t;

endpackage

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int CNT_W = wdt_steer_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             expire_d;

    always_comb begin
        cnt_d    = cnt_q;
        expire_d = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d    = cnt_q - 1'b1;
            expire_d = (cnt_q == CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = expire_d;

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && (cnt_q == '0)) |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             flag_rd_i,
    input  logic             expire_i,
    output logic [REG_W-1:0] ctrl_o,
    output logic             stat_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             rst_o
);

    wdt_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        r_d.rst = 1'b0;
        if (wr_i && wr_sel_i)  r_d.stat = wr_data_i[STAT_POS];
        if (flag_rd_i)         r_d.flag = 1'b0;
        if (wr_i && !wr_sel_i) begin
            r_d.ctrl = wr_data_i;
            r_d.flag = 1'b0;
        end
        // expiry cannot coincide with a reload: the counter gives loads priority
        if (expire_i) begin
            r_d.flag = 1'b1;
            if (r_q.ctrl[STEER_POS]) begin
                r_d.ctrl = '0;
                r_d.stat = 1'b0;
                r_d.rst  = 1'b1;
            end else begin
                r_d.irq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl_o = r_q.ctrl;
    assign stat_o = r_q.stat;
    assign flag_o = r_q.flag;
    assign irq_o  = r_q.irq;
    assign rst_o  = r_q.rst;

    // R7
    irq_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && !r_q.ctrl[STEER_POS]) |=> (r_q.irq && !r_q.rst));

    // R8
    rst_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && r_q.ctrl[STEER_POS]) |=> (r_q.rst && !r_q.irq && (r_q.ctrl == '0) && !r_q.stat));

    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.flag) |-> $past(expire_i));

    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.irq |=> !r_q.irq);

    // R8
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rst |=> !r_q.rst);

endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
    import wdt_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic             wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             flag_rd_i,
    output logic             wd_flag_o,
    output logic             irq_o,
    output logic             rst_req_o,
    output logic [REG_W-1:0] ctrl_o,
    output logic             stat_o
);

    logic             load;
    logic [REG_W-1:0] load_src;
    logic [MULT_W-1:0] mult;
    logic [EXP_W-1:0] expo;
    logic [CNT_W-1:0] load_val;
    logic             expire;

    // a control write loads the new byte; a flags read reloads the stored one
    always_comb begin
        load     = (wr_i && !wr_sel_i) || flag_rd_i;
        load_src = (wr_i && !wr_sel_i) ? wr_data_i : ctrl_o;
        mult     = load_src[MULT_LSB +: MULT_W];
        expo     = load_src[EXP_W-1:0];
        load_val = CNT_W'(mult) << {expo, 1'b0};
    end

    wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .tick_i     (tick_i),
        .expire_o   (expire)
    );

    wdt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .flag_rd_i (flag_rd_i),
        .expire_i  (expire),
        .ctrl_o    (ctrl_o),
        .stat_o    (stat_o),
        .flag_o    (wd_flag_o),
        .irq_o     (irq_o),
        .rst_o     (rst_req_o)
    );

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!irq_o && !rst_req_o));

    // R4
    zero_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (mult == '0)) |=> !irq_o);

endmodule

// File: tb/wdt_steer_test.sv
module wdt_steer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_i = 1'b0;
    logic       wr_sel_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       flag_rd_i = 1'b0;
    logic       wd_flag_o, irq_o, rst_req_o, stat_o;
    logic [7:0] ctrl_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int exp_kind[$];
    int exp_cyc[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_steer uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .flag_rd_i(flag_rd_i),
        .wd_flag_o(wd_flag_o), .irq_o(irq_o), .rst_req_o(rst_req_o),
        .ctrl_o(ctrl_o), .stat_o(stat_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // one clock of stimulus, launched and retired at falling edges
    task automatic drive(bit t, bit w, bit s, logic [7:0] d, bit r);
        tick_i = t; wr_i = w; wr_sel_i = s; wr_data_i = d; flag_rd_i = r;
        @(negedge clk);
        tick_i = 0; wr_i = 0; wr_sel_i = 0; wr_data_i = 8'h00; flag_rd_i = 0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) drive(1, 0, 0, 8'h00, 0);
    endtask

    // push a predicted pulse (0 irq, 1 reset) then deliver the final tick
    task automatic final_tick(int kind);
        exp_kind.push_back(kind);
        exp_cyc.push_back(cyc + 1);
        drive(1, 0, 0, 8'h00, 0);
    endtask

    task automatic wr_ctrl(logic [7:0] d); drive(0, 1, 0, d, 0); endtask
    task automatic wr_stat(logic [7:0] d); drive(0, 1, 1, d, 0); endtask

    // monitor: every pulse must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && (irq_o || rst_req_o)) begin
            checks++;
            if (exp_kind.size() == 0) begin
                failures++;
                $display("FAIL R7/R8/R11 unexpected pulse actual=irq%0b_rst%0b expected=none at cycle %0d",
                         irq_o, rst_req_o, cyc);
            end else begin
                int k, c;
                k = exp_kind.pop_front();
                c = exp_cyc.pop_front();
                if ((irq_o !== (k == 0)) || (rst_req_o !== (k == 1)) || (cyc != c)) begin
                    failures++;
                    $display("FAIL R3/R7/R8 pulse actual=irq%0b_rst%0b@%0d expected=kind%0d@%0d",
                             irq_o, rst_req_o, cyc, k, c);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 flag", wd_flag_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 rst", rst_req_o, 0);
        chk("R1 ctrl", ctrl_o, 0);
        chk("R1 stat", stat_o, 0);
        ticks(5);

        // R9 status write
        wr_stat(8'h40);
        chk("R9 stat set", stat_o, 1);
        chk("R9 ctrl untouched", ctrl_o, 0);

        // R2/R3/R7: m=3 e=1 -> 12 ticks, interrupt steering
        wr_ctrl(8'h0D);
        chk("R2 ctrl stored", ctrl_o, 8'h0D);
        ticks(11);
        chk("R3 no early expiry e1", wd_flag_o, 0);
        final_tick(0);
        chk("R6 flag set", wd_flag_o, 1);
        chk("R7 ctrl kept", ctrl_o, 8'h0D);
        chk("R7 stat kept", stat_o, 1);

        // R11 one-shot
        ticks(20);
        chk("R11 flag sticky", wd_flag_o, 1);

        // R5 flags read reloads and clears
        drive(0, 0, 0, 8'h00, 1);
        chk("R5 flag cleared", wd_flag_o, 0);
        ticks(11);
        chk("R5 reload full timeout", wd_flag_o, 0);
        final_tick(0);
        chk("R5 expiry after reload", wd_flag_o, 1);

        // R2 write clears flag; R9 status write mid-count keeps counting (m=31 e=0)
        wr_ctrl(8'h7C);
        chk("R2 flag cleared", wd_flag_o, 0);
        ticks(10);
        wr_stat(8'h00);
        chk("R9 stat cleared", stat_o, 0);
        ticks(20);
        chk("R9 no early expiry", wd_flag_o, 0);
        final_tick(0);
        chk("R9 count not restarted", wd_flag_o, 1);

        // R10 reload together with final tick (m=2 e=0)
        wr_ctrl(8'h08);
        ticks(1);
        drive(1, 0, 0, 8'h00, 1);
        chk("R10 no expiry on collision", wd_flag_o, 0);
        ticks(1);
        chk("R10 full restart", wd_flag_o, 0);
        final_tick(0);
        chk("R10 expiry after restart", wd_flag_o, 1);

        // R4 zero multiplier (e=3)
        wr_ctrl(8'h03);
        ticks(300);
        chk("R4 never expires", wd_flag_o, 0);

        // R8 reset steering: m=1 e=2 -> 16 ticks
        wr_stat(8'h40);
        wr_ctrl(8'h86);
        ticks(15);
        chk("R3 no early expiry e2", wd_flag_o, 0);
        final_tick(1);
        chk("R8 ctrl cleared", ctrl_o, 0);
        chk("R8 stat cleared", stat_o, 0);
        chk("R8 flag set", wd_flag_o, 1);
        ticks(10);

        // R3 largest exponent: m=2 e=3 -> 128 ticks
        wr_ctrl(8'h0B);
        ticks(127);
        chk("R3 no early expiry e3", wd_flag_o, 0);
        final_tick(0);
        chk("R3 expiry e3", wd_flag_o, 1);

        // R2 rewrite restarts: m=2 e=1 -> 8 ticks
        wr_ctrl(8'h09);
        ticks(5);
        wr_ctrl(8'h09);
        ticks(7);
        chk("R2 restart on rewrite", wd_flag_o, 0);
        final_tick(0);
        chk("R2 expiry after rewrite", wd_flag_o, 1);

        ticks(4);
        chk("R11 all predicted pulses seen", exp_kind.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule